// File: doc/BRIEF.md
# Receive Frame Host Read Port

This block sits between the receive side of a packet controller and a 16-bit host port. A byte stream from the receive logic is collected into a small ring of fixed-size frame slots. Each completed frame carries a 16-bit status word that is supplied with its last byte. The host sees one frame at a time. It reads a fixed stream through one port: the status word, then a byte-count word, then the frame bytes in arrival order. Byte reads and word reads may be mixed. A random word read can fetch any even offset inside an early window of the frame data without moving the stream pointer.

The current frame is given up in three ways: the host reads the clear-on-read event register, the host issues a skip, or the sequential pointer passes the last byte. After a release the reader spends one cycle in its empty state. It then takes the next stored frame, if there is one, with the pointer back at the status position. Bytes marked as CRC are stored and counted only when the keep-CRC input is high.

The reader state machine has four states. RD_EMPTY means no frame is current. RD_STATUS, RD_LENGTH and RD_DATA mean the pointer is in the status word, the count word or the frame bytes. The transitions are:
- empty to status, when a stored frame is pending;
- status to length to data, as the pointer advances;
- any non-empty state to empty, on a release.

The ingest state machine has three states:
- WR_IDLE: between frames.
- WR_FILL: collecting bytes.
- WR_CLIP: the slot is full, so further bytes are dropped.

The transitions are idle to fill on the first accepted byte, fill to clip when the slot fills, and fill or clip to idle on the last byte.

Top module: `rx_frame_port`

## Requirements
- R1: The sequential stream is status (stream byte 0 = status[7:0], byte 1 = status[15:8]), then length (byte 2 = len[7:0], byte 3 = len[15:8]), then frame data from stream byte 4 on. A word read at even pointer p returns {byte p+1, byte p}.
- R2: With keep_crc high, the length and the stored data include the bytes flagged in_crc. With keep_crc low, those bytes are neither stored nor counted.
- R3: An event read of the current frame returns its status and releases the frame, so a following event read sees the next frame or zero.
- R4: A skip releases the current frame mid-stream. The next frame starts at its status word.
- R5: When a sequential read moves the pointer to or past 4+len, the frame is released. For an odd length, the final word has zero in its upper byte.
- R6: frame_avail is high exactly while a frame is current. It stays low for one cycle after each release. Reads while it is low return zero with hst_rvalid still pulsing. hst_rvalid pulses one cycle after every performed read, and hst_rdata is zero when no read was performed.
- R7: A random word read (hst_rand) at an even data offset of at most RAND_WIN-2 returns {data[off+1], data[off]}, with zero for bytes beyond the length. It leaves the stream pointer unchanged.
- R8: A random read at an odd offset, at an offset above RAND_WIN-2, or with hst_byte set returns zero.
- R9: A byte read returns {8'h00, byte p} and advances the pointer by 1. A sequential word read at an odd pointer returns zero and does not move the pointer.
- R10: Requests in the same cycle resolve by priority: event read first, then skip, then data read. A skip that wins produces no hst_rvalid.
- R11: in_ready is low exactly while NFRM completed frames are stored. Bytes beyond MAXB in one frame are dropped, and the length is capped at MAXB.
- R12: A frame commit and a release in the same cycle both take effect, and frames are delivered in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keep_crc | input | 1 | Store and count bytes flagged as CRC |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_crc | input | 1 | Byte belongs to the frame check sequence |
| in_last | input | 1 | Last byte of the frame |
| in_status | input | 16 | Frame status, sampled with the last byte |
| in_ready | output | 1 | A frame slot is free; bytes are accepted |
| hst_rd | input | 1 | Host read request |
| hst_byte | input | 1 | Read is a byte read |
| hst_rand | input | 1 | Read is a random word read at hst_addr |
| hst_addr | input | clog2(MAXB) | Data offset for random reads |
| hst_evt_rd | input | 1 | Read of the clear-on-read event register |
| hst_skip | input | 1 | Skip command |
| hst_rdata | output | 16 | Read data, one cycle after the request |
| hst_rvalid | output | 1 | Read data valid |
| frame_avail | output | 1 | A frame is current |

## Verification
The case most likely to break the bookkeeping is the receive side committing a finished frame in the same cycle that the host releases the current one. The bench provokes it by driving the last byte and an event read on the same edge while other frames are queued. The check has two parts. in_ready must stay unchanged. Draining the queue with event reads must then return every stored status, in arrival order, with none lost or repeated. The cycle-level reference model is compared against the ports on every clock, so a miscount in either path shows up as a status or in_ready mismatch.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    typedef enum logic [1:0] {
        RD_EMPTY,
        RD_STATUS,
        RD_LENGTH,
        RD_DATA
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_FILL,
        WR_CLIP
    } wr_state_e;

endpackage

// File: rtl/rfp_ingest.sv
module rfp_ingest
    import rfp_pkg::*;
#(
    parameter int MAXB = 256,
    parameter int LENW = 16,
    localparam int OFFW = $clog2(MAXB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            keep_crc,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_crc,
    input  logic            in_last,
    input  logic [15:0]     in_status,
    input  logic            slots_full,
    output logic            in_ready,
    output logic            wr_en,
    output logic [OFFW-1:0] wr_off,
    output logic [7:0]      wr_byte,
    output logic            commit,
    output logic [LENW-1:0] commit_len,
    output logic [15:0]     commit_status
);

    wr_state_e       state, state_n;
    logic [LENW-1:0] wlen, wlen_n;
    logic            acc;
    logic            keep_byte;

    assign in_ready      = !slots_full;
    assign acc           = in_valid && in_ready;
    assign keep_byte     = acc && (!in_crc || keep_crc) && (state != WR_CLIP);
    assign wr_en         = keep_byte;
    assign wr_off        = wlen[OFFW-1:0];
    assign wr_byte       = in_data;
    assign commit        = acc && in_last;
    assign commit_len    = wlen + LENW'(keep_byte);
    assign commit_status = in_status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_IDLE;
            wlen  <= '0;
        end else begin
            state <= state_n;
            wlen  <= wlen_n;
        end
    end

    always_comb begin
        state_n = state;
        wlen_n  = wlen;
        unique case (state)
            WR_IDLE, WR_FILL: begin
                if (acc) begin
                    if (in_last) begin
                        state_n = WR_IDLE;
                        wlen_n  = '0;
                    end else if (keep_byte && wlen == LENW'(MAXB - 1)) begin
                        state_n = WR_CLIP;
                        wlen_n  = LENW'(MAXB);
                    end else begin
                        state_n = WR_FILL;
                        wlen_n  = wlen + LENW'(keep_byte);
                    end
                end
            end
            WR_CLIP: begin
                if (acc && in_last) begin
                    state_n = WR_IDLE;
                    wlen_n  = '0;
                end
            end
            default: begin
                state_n = WR_IDLE;
                wlen_n  = '0;
            end
        endcase
    end

    // R11
    wlen_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wlen <= LENW'(MAXB));

    // R11
    clip_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_CLIP) |-> (wlen == LENW'(MAXB)));

endmodule

// File: rtl/rfp_store.sv
module rfp_store #(
    parameter int NFRM = 4,
    parameter int MAXB = 256,
    parameter int LENW = 16,
    localparam int SLW  = $clog2(NFRM),
    localparam int OFFW = $clog2(MAXB),
    localparam int CNTW = SLW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OFFW-1:0] wr_off,
    input  logic [7:0]      wr_byte,
    input  logic            commit,
    input  logic [LENW-1:0] commit_len,
    input  logic [15:0]     commit_status,
    input  logic            release_i,
    input  logic [OFFW-1:0] rd_off0,
    input  logic [OFFW-1:0] rd_off1,
    output logic            slots_full,
    output logic            frame_pending,
    output logic [LENW-1:0] cur_len,
    output logic [15:0]     cur_status,
    output logic [7:0]      rd_byte0,
    output logic [7:0]      rd_byte1
);

    // NFRM and MAXB are powers of two, NFRM at least 2
    logic [7:0]      mem [NFRM*MAXB];
    logic [LENW-1:0] len_q [NFRM];
    logic [15:0]     st_q  [NFRM];
    logic [SLW-1:0]  head;
    logic [SLW-1:0]  wslot;
    logic [CNTW-1:0] cnt;

    assign wslot         = head + cnt[SLW-1:0];
    assign slots_full    = (cnt == CNTW'(NFRM));
    assign frame_pending = (cnt != '0);
    assign cur_len       = len_q[head];
    assign cur_status    = st_q[head];
    assign rd_byte0      = mem[{head, rd_off0}];
    assign rd_byte1      = mem[{head, rd_off1}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wslot, wr_off}] <= wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFRM; i++) begin
                len_q[i] <= '0;
                st_q[i]  <= '0;
            end
        end else if (commit) begin
            len_q[wslot] <= commit_len;
            st_q[wslot]  <= commit_status;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (release_i) begin
                head <= head + 1'b1;
            end
            cnt <= cnt + CNTW'(commit) - CNTW'(release_i);
        end
    end

    // R11
    commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !slots_full);

    // R12
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> frame_pending);

    // R12
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && release_i) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/rfp_reader.sv
module rfp_reader
    import rfp_pkg::*;
#(
    parameter int MAXB     = 256,
    parameter int LENW     = 16,
    parameter int RAND_WIN = 118,
    localparam int OFFW = $clog2(MAXB),
    localparam int PW   = LENW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_rd,
    input  logic            hst_byte,
    input  logic            hst_rand,
    input  logic [OFFW-1:0] hst_addr,
    input  logic            hst_evt_rd,
    input  logic            hst_skip,
    input  logic            frame_pending,
    input  logic [LENW-1:0] cur_len,
    input  logic [15:0]     cur_status,
    input  logic [7:0]      rd_byte0,
    input  logic [7:0]      rd_byte1,
    output logic [OFFW-1:0] rd_off0,
    output logic [OFFW-1:0] rd_off1,
    output logic            release_o,
    output logic [15:0]     hst_rdata,
    output logic            hst_rvalid,
    output logic            frame_avail
);

    rd_state_e     state, state_n;
    logic [PW-1:0] ptr, ptr_n;
    logic [PW-1:0] end_pos;
    logic [PW-1:0] lo_pos, hi_pos;
    logic [7:0]    lo_b, hi_b;
    logic          do_evt, do_skip, do_rd;
    logic          rand_ok;
    logic [15:0]   rdata_n;
    logic          rvalid_n;

    assign end_pos     = {1'b0, cur_len} + PW'(4);
    assign frame_avail = (state != RD_EMPTY);

    assign lo_pos  = hst_rand ? ({{(PW-OFFW){1'b0}}, hst_addr} + PW'(4)) : ptr;
    assign hi_pos  = lo_pos + PW'(1);
    assign rd_off0 = lo_pos[OFFW-1:0] - OFFW'(4);
    assign rd_off1 = hi_pos[OFFW-1:0] - OFFW'(4);

    assign rand_ok = !hst_byte && !hst_addr[0] && (int'(hst_addr) <= RAND_WIN - 2);

    assign do_evt  = hst_evt_rd;
    assign do_skip = !hst_evt_rd && hst_skip;
    assign do_rd   = !hst_evt_rd && !hst_skip && hst_rd;

    function automatic logic [7:0] stream_byte(input logic [PW-1:0] pos,
                                               input logic [7:0]    mb);
        if (pos < PW'(4)) begin
            unique case (pos[1:0])
                2'd0:    return cur_status[7:0];
                2'd1:    return cur_status[15:8];
                2'd2:    return cur_len[7:0];
                default: return cur_len[15:8];
            endcase
        end
        return (pos < end_pos) ? mb : 8'h00;
    endfunction

    function automatic rd_state_e region(input logic [PW-1:0] pos);
        if (pos < PW'(2)) return RD_STATUS;
        if (pos < PW'(4)) return RD_LENGTH;
        return RD_DATA;
    endfunction

    assign lo_b = stream_byte(lo_pos, rd_byte0);
    assign hi_b = stream_byte(hi_pos, rd_byte1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_EMPTY;
            ptr   <= '0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_rdata  <= '0;
            hst_rvalid <= 1'b0;
        end else begin
            hst_rdata  <= rdata_n;
            hst_rvalid <= rvalid_n;
        end
    end

    always_comb begin
        state_n   = state;
        ptr_n     = ptr;
        release_o = 1'b0;
        rdata_n   = '0;
        rvalid_n  = do_evt || do_rd;
        unique case (state)
            RD_EMPTY: begin
                if (frame_pending) begin
                    state_n = RD_STATUS;
                    ptr_n   = '0;
                end
            end
            RD_STATUS, RD_LENGTH, RD_DATA: begin
                if (do_evt) begin
                    rdata_n   = cur_status;
                    release_o = 1'b1;
                end else if (do_skip) begin
                    release_o = 1'b1;
                end else if (do_rd) begin
                    if (hst_rand) begin
                        if (rand_ok) begin
                            rdata_n = {hi_b, lo_b};
                        end
                    end else if (hst_byte) begin
                        rdata_n = {8'h00, lo_b};
                        ptr_n   = ptr + PW'(1);
                    end else if (!ptr[0]) begin
                        rdata_n = {hi_b, lo_b};
                        ptr_n   = ptr + PW'(2);
                    end
                    if (ptr_n >= end_pos) begin
                        release_o = 1'b1;
                    end
                end
                if (release_o) begin
                    state_n = RD_EMPTY;
                    ptr_n   = '0;
                end else begin
                    state_n = region(ptr_n);
                end
            end
        endcase
    end

    // R6
    rel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !frame_avail);

    // R5
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_avail |-> (ptr < end_pos));

    // R7
    rand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_avail && hst_rd && hst_rand && !hst_evt_rd && !hst_skip) |=> $stable(ptr));

    // R3
    evt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_avail && hst_evt_rd) |=> (hst_rvalid && hst_rdata == $past(cur_status)));

    // R10
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_skip && !hst_evt_rd) |=> !hst_rvalid);

    // R9
    odd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_avail && hst_rd && !hst_byte && !hst_rand && ptr[0] && !hst_evt_rd && !hst_skip)
        |=> (hst_rdata == 16'h0000 && $stable(ptr)));

endmodule

// File: rtl/rx_frame_port.sv
module rx_frame_port #(
    parameter int NFRM     = 4,
    parameter int MAXB     = 256,
    parameter int RAND_WIN = 118,
    localparam int OFFW = $clog2(MAXB),
    localparam int LENW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            keep_crc,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_crc,
    input  logic            in_last,
    input  logic [15:0]     in_status,
    output logic            in_ready,
    input  logic            hst_rd,
    input  logic            hst_byte,
    input  logic            hst_rand,
    input  logic [OFFW-1:0] hst_addr,
    input  logic            hst_evt_rd,
    input  logic            hst_skip,
    output logic [15:0]     hst_rdata,
    output logic            hst_rvalid,
    output logic            frame_avail
);

    logic            wr_en;
    logic [OFFW-1:0] wr_off;
    logic [7:0]      wr_byte;
    logic            commit;
    logic [LENW-1:0] commit_len;
    logic [15:0]     commit_status;
    logic            slots_full;
    logic            frame_pending;
    logic            rel;
    logic [LENW-1:0] cur_len;
    logic [15:0]     cur_status;
    logic [OFFW-1:0] rd_off0, rd_off1;
    logic [7:0]      rd_byte0, rd_byte1;

    rfp_ingest #(.MAXB(MAXB), .LENW(LENW)) u_ingest (
        .clk           (clk),
        .rst_n         (rst_n),
        .keep_crc      (keep_crc),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_crc        (in_crc),
        .in_last       (in_last),
        .in_status     (in_status),
        .slots_full    (slots_full),
        .in_ready      (in_ready),
        .wr_en         (wr_en),
        .wr_off        (wr_off),
        .wr_byte       (wr_byte),
        .commit        (commit),
        .commit_len    (commit_len),
        .commit_status (commit_status)
    );

    rfp_store #(.NFRM(NFRM), .MAXB(MAXB), .LENW(LENW)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_off        (wr_off),
        .wr_byte       (wr_byte),
        .commit        (commit),
        .commit_len    (commit_len),
        .commit_status (commit_status),
        .release_i     (rel),
        .rd_off0       (rd_off0),
        .rd_off1       (rd_off1),
        .slots_full    (slots_full),
        .frame_pending (frame_pending),
        .cur_len       (cur_len),
        .cur_status    (cur_status),
        .rd_byte0      (rd_byte0),
        .rd_byte1      (rd_byte1)
    );

    rfp_reader #(.MAXB(MAXB), .LENW(LENW), .RAND_WIN(RAND_WIN)) u_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .hst_rd        (hst_rd),
        .hst_byte      (hst_byte),
        .hst_rand      (hst_rand),
        .hst_addr      (hst_addr),
        .hst_evt_rd    (hst_evt_rd),
        .hst_skip      (hst_skip),
        .frame_pending (frame_pending),
        .cur_len       (cur_len),
        .cur_status    (cur_status),
        .rd_byte0      (rd_byte0),
        .rd_byte1      (rd_byte1),
        .rd_off0       (rd_off0),
        .rd_off1       (rd_off1),
        .release_o     (rel),
        .hst_rdata     (hst_rdata),
        .hst_rvalid    (hst_rvalid),
        .frame_avail   (frame_avail)
    );

endmodule

// File: tb/rx_frame_port_bench.sv
`timescale 1ns/1ps
module rx_frame_port_bench;

    localparam int NFRM = 4;
    localparam int MAXB = 256;
    localparam int RWIN = 118;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        keep_crc = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_crc = 1'b0;
    logic        in_last = 1'b0;
    logic [15:0] in_status = '0;
    logic        in_ready;
    logic        hst_rd = 1'b0;
    logic        hst_byte = 1'b0;
    logic        hst_rand = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic        hst_evt_rd = 1'b0;
    logic        hst_skip = 1'b0;
    logic [15:0] hst_rdata;
    logic        hst_rvalid;
    logic        frame_avail;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_frame_port #(.NFRM(NFRM), .MAXB(MAXB), .RAND_WIN(RWIN)) u_rx_frame_port (
        .clk(clk), .rst_n(rst_n), .keep_crc(keep_crc),
        .in_valid(in_valid), .in_data(in_data), .in_crc(in_crc), .in_last(in_last),
        .in_status(in_status), .in_ready(in_ready),
        .hst_rd(hst_rd), .hst_byte(hst_byte), .hst_rand(hst_rand), .hst_addr(hst_addr),
        .hst_evt_rd(hst_evt_rd), .hst_skip(hst_skip),
        .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .frame_avail(frame_avail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + 3 * i);
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [7:0]  bytes_q[$];
    int          lenq[$];
    logic [15:0] stq[$];
    logic [7:0]  wq[$];
    bit          m_avail = 0;
    int          m_ptr = 0;
    logic [15:0] m_rdata = '0;
    bit          m_rvalid = 0;
    bit          m_ready = 1;

    function automatic logic [7:0] mbyte(input int pos);
        if (pos == 0) return stq[0][7:0];
        if (pos == 1) return stq[0][15:8];
        if (pos == 2) return 8'(lenq[0]);
        if (pos == 3) return 8'(lenq[0] >> 8);
        if (pos - 4 < lenq[0]) return bytes_q[pos - 4];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bytes_q.delete(); lenq.delete(); stq.delete(); wq.delete();
            m_avail = 0; m_ptr = 0; m_rdata = '0; m_rvalid = 0; m_ready = 1;
        end else begin
            int  sz0;
            bit  ev, sk, rd, rel;
            logic [15:0] d;
            sz0 = lenq.size();
            ev = hst_evt_rd;
            sk = !hst_evt_rd && hst_skip;
            rd = !hst_evt_rd && !hst_skip && hst_rd;
            d = '0;
            rel = 0;
            if (!m_avail) begin
                if (sz0 > 0) begin m_avail = 1; m_ptr = 0; end
            end else begin
                if (ev) begin d = stq[0]; rel = 1; end
                else if (sk) rel = 1;
                else if (rd) begin
                    if (hst_rand) begin
                        if (!hst_byte && !hst_addr[0] && int'(hst_addr) <= RWIN - 2)
                            d = {mbyte(int'(hst_addr) + 5), mbyte(int'(hst_addr) + 4)};
                    end else if (hst_byte) begin
                        d = {8'h00, mbyte(m_ptr)};
                        m_ptr = m_ptr + 1;
                    end else if (m_ptr % 2 == 0) begin
                        d = {mbyte(m_ptr + 1), mbyte(m_ptr)};
                        m_ptr = m_ptr + 2;
                    end
                    if (m_ptr >= lenq[0] + 4) rel = 1;
                end
                if (rel) begin
                    for (int k = 0; k < lenq[0]; k++) void'(bytes_q.pop_front());
                    void'(lenq.pop_front());
                    void'(stq.pop_front());
                    m_avail = 0;
                    m_ptr = 0;
                end
            end
            m_rdata = d;
            m_rvalid = ev || rd;
            if (in_valid && sz0 < NFRM) begin
                if ((!in_crc || keep_crc) && wq.size() < MAXB) wq.push_back(in_data);
                if (in_last) begin
                    foreach (wq[k]) bytes_q.push_back(wq[k]);
                    lenq.push_back(wq.size());
                    stq.push_back(in_status);
                    wq.delete();
                end
            end
            m_ready = (lenq.size() < NFRM);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 rdata vs model", int'(hst_rdata), int'(m_rdata));
            chk("R6 rvalid vs model", int'(hst_rvalid), int'(m_rvalid));
            chk("R6 frame_avail vs model", int'(frame_avail), int'(m_avail));
            chk("R11 in_ready vs model", int'(in_ready), int'(m_ready));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic push_frame(input logic [7:0] seed, input int n, input int c,
                              input logic [15:0] st, input bit hold_last);
        int tot;
        tot = n + c;
        for (int i = 0; i < tot; i++) begin
            if (hold_last && i == tot - 1) break;
            @(negedge clk);
            while (!in_ready) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data = pat(seed, i);
            in_crc = (i >= n);
            in_last = (i == tot - 1);
            in_status = st;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_crc = 1'b0;
    endtask

    task automatic hop(input logic rd, input logic byt, input logic rnd, input logic [7:0] adr,
                       input logic evt, input logic skp,
                       output logic [15:0] d, output logic v);
        @(negedge clk);
        hst_rd = rd; hst_byte = byt; hst_rand = rnd; hst_addr = adr;
        hst_evt_rd = evt; hst_skip = skp;
        @(negedge clk);
        hst_rd = 0; hst_byte = 0; hst_rand = 0; hst_addr = '0; hst_evt_rd = 0; hst_skip = 0;
        d = hst_rdata;
        v = hst_rvalid;
    endtask

    task automatic wait_avail();
        while (!frame_avail) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        // R6 / R11 reset state
        chk("R6 reset frame_avail", int'(frame_avail), 0);
        chk("R6 reset rvalid", int'(hst_rvalid), 0);
        chk("R6 reset rdata", int'(hst_rdata), 0);
        chk("R11 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 read with no frame returns zero but pulses rvalid
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R6 empty read data", int'(d), 0);
        chk("R6 empty read rvalid", int'(v), 1);

        // R1 R2 R5: CRC dropped, full word read releases
        keep_crc = 1'b0;
        push_frame(8'h10, 10, 4, 16'hA5C3, 0);
        wait_avail();
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R1 status word", int'(d), 16'hA5C3);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R2 length without crc", int'(d), 10);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R1 first data word", int'(d), int'({pat(8'h10, 1), pat(8'h10, 0)}));
        for (int k = 0; k < 3; k++) hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R5 still current before last", int'(frame_avail), 1);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R2 last word no crc", int'(d), int'({pat(8'h10, 9), pat(8'h10, 8)}));
        chk("R5 released after full read", int'(frame_avail), 0);

        // R2 R9 R5: CRC kept, odd length, byte/word mixing
        keep_crc = 1'b1;
        push_frame(8'h40, 5, 4, 16'h5E71, 0);
        wait_avail();
        hop(1, 1, 0, 0, 0, 0, d, v);
        chk("R1 status low byte", int'(d), 16'h0071);
        hop(1, 1, 0, 0, 0, 0, d, v);
        chk("R1 status high byte", int'(d), 16'h005E);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R2 length with crc", int'(d), 9);
        hop(1, 1, 0, 0, 0, 0, d, v);
        chk("R9 byte read data0", int'(d), int'(pat(8'h40, 0)));
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R9 word at odd pointer", int'(d), 0);
        hop(1, 1, 0, 0, 0, 0, d, v);
        chk("R9 byte realigns", int'(d), int'(pat(8'h40, 1)));
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R9 word after realign", int'(d), int'({pat(8'h40, 3), pat(8'h40, 2)}));
        hop(1, 0, 0, 0, 0, 0, d, v);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R2 crc bytes stored", int'(d), int'({pat(8'h40, 7), pat(8'h40, 6)}));
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R5 odd tail word", int'(d), int'(pat(8'h40, 8)));
        chk("R5 released odd length", int'(frame_avail), 0);

        // R7 R8 R3: random window then event read
        keep_crc = 1'b0;
        push_frame(8'h70, 130, 4, 16'h0F0F, 0);
        wait_avail();
        hop(1, 0, 1, 8'd0, 0, 0, d, v);
        chk("R7 random offset 0", int'(d), int'({pat(8'h70, 1), pat(8'h70, 0)}));
        hop(1, 0, 1, 8'd116, 0, 0, d, v);
        chk("R7 random offset 116", int'(d), int'({pat(8'h70, 117), pat(8'h70, 116)}));
        hop(1, 0, 1, 8'd118, 0, 0, d, v);
        chk("R8 random past window", int'(d), 0);
        hop(1, 0, 1, 8'd3, 0, 0, d, v);
        chk("R8 random odd offset", int'(d), 0);
        hop(1, 1, 1, 8'd4, 0, 0, d, v);
        chk("R8 random byte read", int'(d), 0);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R7 pointer unchanged by random", int'(d), 16'h0F0F);
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R3 event returns status", int'(d), 16'h0F0F);
        chk("R3 event releases", int'(frame_avail), 0);
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R3 event cleared", int'(d), 0);

        // R4 R10: skip mid-frame, priority
        push_frame(8'h21, 20, 0, 16'h0A0A, 0);
        push_frame(8'h33, 6, 0, 16'h0B0B, 0);
        wait_avail();
        for (int k = 0; k < 3; k++) hop(1, 0, 0, 0, 0, 0, d, v);
        hop(0, 0, 0, 0, 0, 1, d, v);
        chk("R4 skip releases", int'(frame_avail), 0);
        wait_avail();
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R4 next frame starts at status", int'(d), 16'h0B0B);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R4 next frame length", int'(d), 6);
        hop(1, 0, 0, 0, 1, 1, d, v);
        chk("R10 event wins", int'(d), 16'h0B0B);
        push_frame(8'h55, 4, 0, 16'h3333, 0);
        wait_avail();
        hop(1, 0, 0, 0, 0, 1, d, v);
        chk("R10 skip beats read rvalid", int'(v), 0);
        chk("R10 skip beats read release", int'(frame_avail), 0);

        // R11 R12: full store, commit and release together
        for (int k = 0; k < 4; k++) push_frame(8'(8'h81 + k), 3, 0, 16'(16'h1001 + k), 0);
        chk("R11 in_ready low when full", int'(in_ready), 0);
        wait_avail();
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R3 first of four", int'(d), 16'h1001);
        chk("R11 in_ready after release", int'(in_ready), 1);
        wait_avail();
        push_frame(8'h90, 4, 0, 16'h2222, 1);
        @(negedge clk);
        in_valid = 1; in_data = pat(8'h90, 3); in_last = 1; in_status = 16'h2222;
        hst_evt_rd = 1;
        @(negedge clk);
        in_valid = 0; in_last = 0; hst_evt_rd = 0;
        chk("R12 released status", int'(hst_rdata), 16'h1002);
        chk("R12 count kept", int'(in_ready), 1);
        wait_avail();
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R12 order 3", int'(d), 16'h1003);
        wait_avail();
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R12 order 4", int'(d), 16'h1004);
        wait_avail();
        hop(0, 0, 0, 0, 1, 0, d, v);
        chk("R12 committed frame present", int'(d), 16'h2222);

        // R11 oversize frame capped
        push_frame(8'h05, 260, 0, 16'h7777, 0);
        wait_avail();
        hop(1, 0, 0, 0, 0, 0, d, v);
        hop(1, 0, 0, 0, 0, 0, d, v);
        chk("R11 length capped", int'(d), MAXB);
        hop(1, 0, 1, 8'd2, 0, 0, d, v);
        chk("R11 kept bytes intact", int'(d), int'({pat(8'h05, 3), pat(8'h05, 2)}));
        hop(0, 0, 0, 0, 0, 1, d, v);
        repeat (3) @(negedge clk);
        chk("R6 idle at end", int'(frame_avail), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule